// File: doc/BRIEF.md
# Multicycle Fetch-Execute Sequencer Core

This block is a small non-pipelined processor. It repeats one loop: fetch a word from a single shared memory that holds both code and data, advance the program counter by one word, then decode and execute the fetched word. It implements four operations: a register-to-register add, a word load, a word store and an indirect jump through a register. The register file has 32 entries of 32 bits, and entry 0 always reads as zero.

Every memory transfer goes through an address register and a data register. The core presents a request on a single request/ready port and holds it until the memory signals ready. A run ends when the program jumps to a configurable return sentinel, normally preloaded into register 31. A word the core cannot decode, and any access or jump to an address that is not word aligned, stop the core with an illegal flag.

A debug port can read and write any register. This lets an environment preload operands while the first fetch is stalled, and read results once the core has halted.

Top module: `seq_core`

## Requirements
- R1: While reset is held and on release, the core requests a read (`mem_we_o`=0) at address `RESET_PC` (default 0), with `halted_o` and `illegal_o` low.
- R2: Each fetch loads the instruction word and advances the PC by 4, so straight-line code is fetched at consecutive word addresses. The cycle after a fetch handshake carries no request.
- R3: A word with opcode bits[31:26]=000000, funct bits[5:0]=100000 and bits[10:6]=0 writes rs+rt (mod 2^32) into rd, with rs in bits[25:21], rt in bits[20:16] and rd in bits[15:11].
- R4: Register 0 reads as zero. Writes to it, from the core or from the debug port, are discarded.
- R5: Opcode 100011 loads the word at rs + sign-extended bits[15:0] into rt.
- R6: Opcode 101011 writes rt to memory at rs + sign-extended bits[15:0].
- R7: While `mem_req_o` is high and `mem_ready_i` is low, the core keeps the request, address, write enable and write data unchanged and does nothing else.
- R8: Opcode 000000 with funct 001000 and bits[20:6]=0 sets the PC to rs. The next fetch is at that address, and the word after the jump is never fetched.
- R9: A jump whose target equals `HALT_ADDR` (default 0xFFFFFFFC) raises `halted_o`, which then stays high with no further requests and `illegal_o` low.
- R10: Any other instruction word raises `illegal_o` and `halted_o`, leaves the registers unchanged and issues no further requests.
- R11: A load or store effective address, or a jump target other than `HALT_ADDR`, with bits[1:0] not equal to 00 raises `illegal_o` and `halted_o` without any memory access.
- R12: The debug port writes register `dbg_waddr_i` at the clock edge while `dbg_we_i` is high. If the core writes the same register in the same cycle, the core's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address from the address register |
| mem_wdata_o | output | 32 | Write data from the data register |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Memory completes the request this cycle |
| halted_o | output | 1 | Core has stopped |
| illegal_o | output | 1 | Stop was caused by a bad word or a misaligned address |
| dbg_raddr_i | input | 5 | Debug read register index |
| dbg_rdata_o | output | 32 | Debug read data (combinational) |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_waddr_i | input | 5 | Debug write register index |
| dbg_wdata_i | input | 32 | Debug write data |

## Verification
A core register write-back and a debug register write can land in the same cycle. The add write-back happens in the decode cycle, one cycle after the fetch handshake.

The bench watches the port for the handshake that fetches the add. It drives a debug write of a marker value to the add's destination in exactly the following cycle. After the core halts, the bench reads that register back through the debug port. The register must hold the sum and not the marker.

// File: rtl/seq_core_pkg.sv
package seq_core_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned NREGS  = 1 << REG_AW;

  localparam logic [5:0] OPC_SPECIAL = 6'b000000;
  localparam logic [5:0] OPC_LOAD    = 6'b100011;
  localparam logic [5:0] OPC_STORE   = 6'b101011;
  localparam logic [5:0] FN_ADD      = 6'b100000;
  localparam logic [5:0] FN_JUMPR    = 6'b001000;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_MEM,
    ST_WB,
    ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_LOAD,
    OP_STORE,
    OP_JUMPR,
    OP_BAD
  } op_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_core_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  output op_e               op_o,
  output logic [REG_AW-1:0] rs_o,
  output logic [REG_AW-1:0] rt_o,
  output logic [REG_AW-1:0] rd_o,
  output logic [WORD_W-1:0] imm_o
);
  localparam int unsigned IMM_W = 16;

  logic [5:0] opcode, funct;
  logic [4:0] shamt;

  assign opcode = instr_i[31:26];
  assign funct  = instr_i[5:0];
  assign shamt  = instr_i[10:6];
  assign rs_o   = instr_i[25:21];
  assign rt_o   = instr_i[20:16];
  assign rd_o   = instr_i[15:11];
  assign imm_o  = {{(WORD_W-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};

  // strict: unused fields must be zero
  always_comb begin
    op_o = OP_BAD;
    unique case (opcode)
      OPC_SPECIAL: begin
        if (funct == FN_ADD && shamt == '0)
          op_o = OP_ADD;
        else if (funct == FN_JUMPR && instr_i[20:6] == '0)
          op_o = OP_JUMPR;
      end
      OPC_LOAD:  op_o = OP_LOAD;
      OPC_STORE: op_o = OP_STORE;
      default:   op_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned W     = 32
) (
  input  logic                     clk_i,
  input  logic [$clog2(NREGS)-1:0] ra_a_i,
  input  logic [$clog2(NREGS)-1:0] ra_b_i,
  input  logic [$clog2(NREGS)-1:0] ra_d_i,
  output logic [W-1:0]             rd_a_o,
  output logic [W-1:0]             rd_b_o,
  output logic [W-1:0]             rd_d_o,
  input  logic                     core_we_i,
  input  logic [$clog2(NREGS)-1:0] core_wa_i,
  input  logic [W-1:0]             core_wd_i,
  input  logic                     dbg_we_i,
  input  logic [$clog2(NREGS)-1:0] dbg_wa_i,
  input  logic [W-1:0]             dbg_wd_i
);
  localparam int unsigned AW = $clog2(NREGS);

  logic [W-1:0] regs_q [1:NREGS-1];

  // entry 0 has no storage; core write outranks debug write per entry
  for (genvar g = 1; g < NREGS; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (core_we_i && core_wa_i == AW'(g))
        regs_q[g] <= core_wd_i;
      else if (dbg_we_i && dbg_wa_i == AW'(g))
        regs_q[g] <= dbg_wd_i;
    end
  end

  function automatic logic [W-1:0] rd_fn(input logic [AW-1:0] a);
    return (a == '0) ? '0 : regs_q[a];
  endfunction

  assign rd_a_o = rd_fn(ra_a_i);
  assign rd_b_o = rd_fn(ra_b_i);
  assign rd_d_o = rd_fn(ra_d_i);
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_core_pkg::*;
#(
  parameter logic [31:0] RESET_PC  = 32'h0000_0000,
  parameter logic [31:0] HALT_ADDR = 32'hFFFF_FFFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              halted_o,
  output logic              illegal_o,
  input  logic [REG_AW-1:0] dbg_raddr_i,
  output logic [WORD_W-1:0] dbg_rdata_o,
  input  logic              dbg_we_i,
  input  logic [REG_AW-1:0] dbg_waddr_i,
  input  logic [WORD_W-1:0] dbg_wdata_i
);
  localparam logic [WORD_W-1:0] WORD_STEP = WORD_W'(4);

  state_e            state_q;
  logic [WORD_W-1:0] pc_q, ir_q, mar_q, mdr_q;
  logic              store_q, illegal_q;
  logic [REG_AW-1:0] dst_q;

  op_e               dec_op;
  logic [REG_AW-1:0] dec_rs, dec_rt, dec_rd;
  logic [WORD_W-1:0] dec_imm;
  logic [WORD_W-1:0] rs_val, rt_val, eff_addr;

  logic              rf_we;
  logic [REG_AW-1:0] rf_wa;
  logic [WORD_W-1:0] rf_wd;

  seq_decode u_dec (
    .instr_i (ir_q),
    .op_o    (dec_op),
    .rs_o    (dec_rs),
    .rt_o    (dec_rt),
    .rd_o    (dec_rd),
    .imm_o   (dec_imm)
  );

  seq_regfile #(.NREGS(NREGS), .W(WORD_W)) u_rf (
    .clk_i     (clk_i),
    .ra_a_i    (dec_rs),
    .ra_b_i    (dec_rt),
    .ra_d_i    (dbg_raddr_i),
    .rd_a_o    (rs_val),
    .rd_b_o    (rt_val),
    .rd_d_o    (dbg_rdata_o),
    .core_we_i (rf_we),
    .core_wa_i (rf_wa),
    .core_wd_i (rf_wd),
    .dbg_we_i  (dbg_we_i),
    .dbg_wa_i  (dbg_waddr_i),
    .dbg_wd_i  (dbg_wdata_i)
  );

  assign eff_addr = rs_val + dec_imm;

  // add retires in decode; load retires in write-back
  always_comb begin
    rf_we = 1'b0;
    rf_wa = dec_rd;
    rf_wd = rs_val + rt_val;
    if (state_q == ST_DECODE && dec_op == OP_ADD) begin
      rf_we = 1'b1;
    end else if (state_q == ST_WB) begin
      rf_we = 1'b1;
      rf_wa = dst_q;
      rf_wd = mdr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FETCH;
      pc_q      <= RESET_PC;
      mar_q     <= RESET_PC;
      ir_q      <= '0;
      mdr_q     <= '0;
      store_q   <= 1'b0;
      dst_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FETCH: if (mem_ready_i) begin
          ir_q    <= mem_rdata_i;
          pc_q    <= pc_q + WORD_STEP;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          unique case (dec_op)
            OP_ADD: begin
              mar_q   <= pc_q;
              state_q <= ST_FETCH;
            end
            OP_LOAD, OP_STORE: begin
              if (eff_addr[1:0] != 2'b00) begin
                illegal_q <= 1'b1;
                state_q   <= ST_HALT;
              end else begin
                mar_q   <= eff_addr;
                mdr_q   <= rt_val;
                store_q <= (dec_op == OP_STORE);
                dst_q   <= dec_rt;
                state_q <= ST_MEM;
              end
            end
            OP_JUMPR: begin
              if (rs_val == HALT_ADDR) begin
                state_q <= ST_HALT;
              end else if (rs_val[1:0] != 2'b00) begin
                illegal_q <= 1'b1;
                state_q   <= ST_HALT;
              end else begin
                pc_q    <= rs_val;
                mar_q   <= rs_val;
                state_q <= ST_FETCH;
              end
            end
            default: begin
              illegal_q <= 1'b1;
              state_q   <= ST_HALT;
            end
          endcase
        end
        ST_MEM: if (mem_ready_i) begin
          if (store_q) begin
            mar_q   <= pc_q;
            state_q <= ST_FETCH;
          end else begin
            mdr_q   <= mem_rdata_i;
            state_q <= ST_WB;
          end
        end
        ST_WB: begin
          mar_q   <= pc_q;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_MEM);
  assign mem_we_o    = (state_q == ST_MEM) && store_q;
  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign halted_o    = (state_q == ST_HALT);
  assign illegal_o   = illegal_q;

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R2
  fetch_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i && !mem_we_o && state_q == ST_FETCH |=> !mem_req_o);

  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o);

  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(illegal_o));

  // R10
  illegal_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illegal_o) |-> halted_o);

  // R11
  aligned_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
endmodule

// File: tb/seq_core_bench.sv
`timescale 1ns/1ps
module seq_core_bench;
  localparam logic [31:0] HALT = 32'hFFFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        mem_req_o, mem_we_o, mem_ready;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata;
  logic        halted_o, illegal_o;
  logic [4:0]  dbg_raddr_i, dbg_waddr_i;
  logic [31:0] dbg_rdata_o, dbg_wdata_i;
  logic        dbg_we_i;

  always #2.5 clk = ~clk;

  seq_core u_seq_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata),
    .mem_ready_i (mem_ready),
    .halted_o    (halted_o),
    .illegal_o   (illegal_o),
    .dbg_raddr_i (dbg_raddr_i),
    .dbg_rdata_o (dbg_rdata_o),
    .dbg_we_i    (dbg_we_i),
    .dbg_waddr_i (dbg_waddr_i),
    .dbg_wdata_i (dbg_wdata_i)
  );

  logic [31:0] ram [256];
  int lat;
  bit hold;
  int n_chk = 0, n_fail = 0;
  int rd_hs, wr_hs, stab_viol;
  bit saw_a4;

  function automatic logic [31:0] enc_add(int d, int s, int t);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, 6'b100000};
  endfunction
  function automatic logic [31:0] enc_jr(int s);
    return {6'b000000, 5'(s), 15'd0, 6'b001000};
  endfunction
  function automatic logic [31:0] enc_lw(int t, int s, logic [15:0] i);
    return {6'b100011, 5'(s), 5'(t), i};
  endfunction
  function automatic logic [31:0] enc_sw(int t, int s, logic [15:0] i);
    return {6'b101011, 5'(s), 5'(t), i};
  endfunction

  // memory model: ready after lat waiting cycles
  initial begin : mem_model
    int wcnt;
    wcnt = 0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req_o && !hold) begin
        if (wcnt >= lat) begin
          mem_ready = 1'b1;
          mem_rdata = ram[mem_addr_o[9:2]];
          if (mem_we_o) ram[mem_addr_o[9:2]] = mem_wdata_o;
          wcnt = 0;
        end else begin
          mem_ready = 1'b0;
          wcnt++;
        end
      end else begin
        mem_ready = 1'b0;
        wcnt = 0;
      end
    end
  end

  // port monitor: handshakes and request stability
  initial begin : monitor
    bit pend;
    logic [31:0] p_addr, p_wd;
    logic p_we;
    pend = 0; p_addr = '0; p_wd = '0; p_we = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni) begin
        if (pend && (!mem_req_o || mem_addr_o != p_addr || mem_we_o != p_we
                     || mem_wdata_o != p_wd))
          stab_viol++;
        pend   = mem_req_o && !mem_ready;
        p_addr = mem_addr_o;
        p_we   = mem_we_o;
        p_wd   = mem_wdata_o;
        if (mem_req_o && mem_ready) begin
          if (mem_we_o) wr_hs++;
          else begin
            rd_hs++;
            if (mem_addr_o == 32'h4) saw_a4 = 1;
          end
        end
      end else pend = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start(int l);
    rst_ni = 1'b0;
    hold = 1'b1;
    lat = l;
    dbg_we_i = 1'b0;
    for (int i = 0; i < 256; i++) ram[i] = '0;
    rd_hs = 0; wr_hs = 0; stab_viol = 0; saw_a4 = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic go();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic setreg(int idx, logic [31:0] v);
    @(negedge clk);
    dbg_we_i = 1'b1;
    dbg_waddr_i = 5'(idx);
    dbg_wdata_i = v;
    @(negedge clk);
    dbg_we_i = 1'b0;
  endtask

  task automatic getreg(int idx, output logic [31:0] v);
    dbg_raddr_i = 5'(idx);
    #1;
    v = dbg_rdata_o;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (halted_o) break;
    end
    #1;
  endtask

  task automatic t_reset();
    start(0);
    ram[0] = enc_jr(31);
    #1;
    chk("R1 req in reset", 32'(mem_req_o), 1);
    chk("R1 we in reset", 32'(mem_we_o), 0);
    chk("R1 addr in reset", mem_addr_o, 0);
    chk("R1 halted low", 32'(halted_o), 0);
    chk("R1 illegal low", 32'(illegal_o), 0);
    go();
    repeat (5) @(negedge clk);
    #1;
    chk("R7 stalled req", 32'(mem_req_o), 1);
    chk("R7 stalled addr", mem_addr_o, 0);
    chk("R7 no handshake", rd_hs, 0);
    setreg(31, HALT);
    hold = 1'b0;
    wait_halt();
    chk("R9 halted", 32'(halted_o), 1);
    chk("R9 illegal low", 32'(illegal_o), 0);
    repeat (4) @(negedge clk);
    #1;
    chk("R9 one fetch only", rd_hs, 1);
    chk("R7 stable while waiting", stab_viol, 0);
  endtask

  task automatic t_add();
    logic [31:0] v;
    start(0);
    ram[0] = enc_add(3, 1, 2);
    ram[1] = enc_add(4, 5, 6);
    ram[2] = enc_jr(31);
    go();
    setreg(1, 5); setreg(2, 7); setreg(5, 32'hFFFF_FFFF); setreg(6, 2);
    setreg(31, HALT);
    hold = 1'b0;
    wait_halt();
    getreg(3, v); chk("R3 add", v, 12);
    getreg(4, v); chk("R3 add wraps", v, 1);
    chk("R2 three sequential fetches", rd_hs, 3);
    chk("R2 no writes", wr_hs, 0);
    chk("R9 halted after add", 32'(halted_o), 1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    start(1);
    ram[0] = enc_add(0, 1, 2);
    ram[1] = enc_add(7, 0, 0);
    ram[2] = enc_jr(31);
    go();
    setreg(1, 32'h11); setreg(2, 32'h22); setreg(7, 32'h5555);
    setreg(0, 32'hABCD); setreg(31, HALT);
    getreg(0, v); chk("R4 debug write to r0 dropped", v, 0);
    hold = 1'b0;
    wait_halt();
    getreg(0, v); chk("R4 core write to r0 dropped", v, 0);
    getreg(7, v); chk("R4 r0 reads zero", v, 0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    start(3);
    ram[0] = enc_lw(3, 1, 16'h0008);
    ram[1] = enc_lw(4, 2, 16'hFFFC);
    ram[2] = enc_jr(31);
    ram[8'h40] = 32'hCAFE_F00D;
    ram[8'h41] = 32'h1234_5678;
    go();
    setreg(1, 32'hF8); setreg(2, 32'h108); setreg(31, HALT);
    hold = 1'b0;
    wait_halt();
    getreg(3, v); chk("R5 load positive offset", v, 32'hCAFE_F00D);
    getreg(4, v); chk("R5 load negative offset", v, 32'h1234_5678);
    chk("R5 read handshakes", rd_hs, 5);
    chk("R7 stable under latency", stab_viol, 0);
  endtask

  task automatic t_store();
    logic [31:0] v;
    start(2);
    ram[0] = enc_sw(2, 1, 16'h0010);
    ram[1] = enc_lw(8, 1, 16'h0010);
    ram[2] = enc_jr(31);
    go();
    setreg(1, 32'h100); setreg(2, 32'h600D_BEEF); setreg(8, 0);
    setreg(31, HALT);
    hold = 1'b0;
    wait_halt();
    chk("R6 stored word", ram[8'h44], 32'h600D_BEEF);
    chk("R6 one write", wr_hs, 1);
    getreg(8, v); chk("R6 load back", v, 32'h600D_BEEF);
    chk("R7 store held", stab_viol, 0);
  endtask

  task automatic t_jump();
    logic [31:0] v;
    start(0);
    ram[0] = enc_jr(5);
    ram[1] = enc_add(6, 6, 6);
    ram[8'h10] = enc_add(6, 1, 1);
    ram[8'h11] = enc_jr(31);
    go();
    setreg(5, 32'h40); setreg(1, 21); setreg(6, 0); setreg(31, HALT);
    hold = 1'b0;
    wait_halt();
    getreg(6, v); chk("R8 code at target ran", v, 42);
    chk("R8 word after jump skipped", 32'(saw_a4), 0);
    chk("R8 fetch count", rd_hs, 3);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    start(0);
    ram[0] = 32'hFC00_0000;
    ram[1] = enc_jr(31);
    go();
    setreg(31, HALT);
    hold = 1'b0;
    wait_halt();
    repeat (5) @(negedge clk);
    #1;
    chk("R10 illegal flag", 32'(illegal_o), 1);
    chk("R10 halted", 32'(halted_o), 1);
    chk("R10 no request", 32'(mem_req_o), 0);
    chk("R10 single fetch", rd_hs, 1);
    start(0);
    ram[0] = enc_add(3, 1, 2) | 32'h0000_0040;
    go();
    setreg(1, 1); setreg(2, 2); setreg(3, 32'h3333);
    hold = 1'b0;
    wait_halt();
    chk("R10 nonzero shift field illegal", 32'(illegal_o), 1);
    getreg(3, v); chk("R10 register untouched", v, 32'h3333);
  endtask

  task automatic t_misalign();
    logic [31:0] v;
    start(0);
    ram[0] = enc_lw(3, 1, 16'h0002);
    go();
    setreg(1, 32'h100); setreg(3, 32'hAAAA_0000); setreg(31, HALT);
    hold = 1'b0;
    wait_halt();
    chk("R11 misaligned load illegal", 32'(illegal_o), 1);
    getreg(3, v); chk("R11 load target untouched", v, 32'hAAAA_0000);
    chk("R11 no data access", rd_hs, 1);
    start(0);
    ram[0] = enc_sw(2, 1, 16'h0001);
    go();
    setreg(1, 32'h100); setreg(2, 32'h77);
    hold = 1'b0;
    wait_halt();
    chk("R11 misaligned store illegal", 32'(illegal_o), 1);
    chk("R11 no write", wr_hs, 0);
    start(0);
    ram[0] = enc_jr(5);
    go();
    setreg(5, 32'h42);
    hold = 1'b0;
    wait_halt();
    chk("R11 misaligned jump illegal", 32'(illegal_o), 1);
    chk("R11 no fetch at target", rd_hs, 1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    start(0);
    ram[0] = enc_add(3, 1, 2);
    ram[1] = enc_jr(31);
    go();
    setreg(1, 100); setreg(2, 23); setreg(3, 0); setreg(31, HALT);
    hold = 1'b0;
    do begin
      @(negedge clk);
      #1;
    end while (!(mem_req_o && mem_ready && !mem_we_o && mem_addr_o == 0));
    @(negedge clk);
    dbg_we_i = 1'b1;
    dbg_waddr_i = 5'd3;
    dbg_wdata_i = 32'hDEAD_0000;
    @(negedge clk);
    dbg_we_i = 1'b0;
    wait_halt();
    getreg(3, v); chk("R12 core write wins collision", v, 123);
    setreg(9, 32'h77);
    getreg(9, v); chk("R12 debug write lands", v, 32'h77);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    rst_ni = 1'b0;
    hold = 1'b1;
    lat = 0;
    dbg_we_i = 1'b0;
    dbg_waddr_i = '0;
    dbg_wdata_i = '0;
    dbg_raddr_i = '0;
    t_reset();
    t_add();
    t_zero();
    t_load();
    t_store();
    t_jump();
    t_illegal();
    t_misalign();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule